// File: doc/BRIEF.md
# Data Valid Window Scan Sequencer

This block calibrates the read strobe delay of a double data rate interface by sweeping every tap of the slave delay line. After a start pulse it forces the slave tap through the override path, one tap at a time in ascending order. It lets each forced tap settle, then asks an external read checker (a BIST engine or a compare unit) to run read traffic. The checker answers with a done pulse and a pass bit. The sequencer keeps the longest unbroken run of passing taps and takes its centre. It then works out how far that centre lies from the master's quarter-cycle value.

At the end of the scan the override is released and the result is presented as an offset magnitude with a direction bit. The slave keeps its master-tracked delay and only adds this correction, so temperature tracking survives calibration. A direction of 1 makes the slave delay shorter and a direction of 0 makes it longer. If no tap passes, an error flag is raised and the offset stays at zero.

States: `ST_IDLE` waits for start. `ST_SETTLE` drives the override for a fixed settle time. `ST_TEST` holds the read request until the checker answers. `ST_CALC` folds the window into an offset. `ST_DONE` presents the result. Transitions: `ST_IDLE`/`ST_DONE` go to `ST_SETTLE` on start. `ST_SETTLE` goes to `ST_TEST` when the settle count expires. `ST_TEST` goes to `ST_SETTLE` on done for taps below the last one, and to `ST_CALC` on done at the last tap. `ST_CALC` always goes to `ST_DONE`.

Top module: `dvw_scan_seq`

## Requirements
- R1: While reset is asserted, and after it is released until a start pulse arrives, ovr_en_o, test_req_o, done_o, err_o, ofs_o and ofs_dir_o are all 0.
- R2: A start pulse in idle or done begins a scan of taps 0 to 2^TAP_W-1 (0 to 127 by default) in ascending order. Each tap gets exactly one read test, and ovr_en_o stays high with the tap on ovr_tap_o for the whole scan.
- R3: For each tap, ovr_tap_o carries the new tap with test_req_o low for exactly SETTLE_CYC (4) cycles before test_req_o rises. ovr_tap_o does not change while test_req_o is high.
- R4: test_req_o stays high until a clock edge at which test_done_i is high. test_pass_i is sampled at that edge, and test_req_o is low in the following cycle.
- R5: The window is the longest run of consecutive passing taps. A tie keeps the run with the lowest start. win_start_o and win_end_o give its first and last tap.
- R6: The centre is floor((win_start+win_end)/2). ofs_o equals |centre - qc|, where qc is qc_i sampled in the cycle of the start pulse.
- R7: ofs_dir_o is 1 (shorter delay) when the centre is below qc, and 0 (longer delay) otherwise, including equality.
- R8: When the scan ends, done_o rises with ovr_en_o low and test_req_o low. done_o and all result outputs hold until the next start pulse.
- R9: If no tap passes, done_o comes with err_o = 1, and ofs_o, ofs_dir_o, win_start_o and win_end_o are all 0.
- R10: A start pulse from done clears done_o and err_o in the next cycle and starts a fresh scan. A start pulse during a scan has no effect on the tap sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that begins a scan |
| qc_i | input | TAP_W | Master quarter-cycle tap count |
| test_done_i | input | 1 | Checker finished the read test for the current tap |
| test_pass_i | input | 1 | Result of that test, valid with test_done_i |
| ovr_en_o | output | 1 | Slave override enable |
| ovr_tap_o | output | TAP_W | Tap forced into the slave |
| test_req_o | output | 1 | Request to the checker to run a read test |
| ofs_o | output | TAP_W | Offset magnitude for the slave |
| ofs_dir_o | output | 1 | Offset direction: 1 shorter, 0 longer |
| win_start_o | output | TAP_W | First tap of the chosen window |
| win_end_o | output | TAP_W | Last tap of the chosen window |
| done_o | output | 1 | Scan complete, results valid |
| err_o | output | 1 | No passing tap was found |

## Verification
The assertions assume that the checker raises test_done_i only while test_req_o is high, and that it answers each request once. They also assume that start_i is a single-cycle pulse. The bench's checker model keeps to this: it counts a latency from the rising request, drives done for one cycle, and then waits for the request to fall. Pass results come from one or two programmed tap windows. These cover an interior window, runs that touch tap 0 and the last tap, equal-length runs, a full pass and an empty map, with offsets in both directions and at zero. One extra start pulse is injected mid-scan to show it is ignored.

// File: rtl/dvw_scan_pkg.sv
package dvw_scan_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_TEST,
        ST_CALC,
        ST_DONE
    } dvw_state_e;
endpackage

// File: rtl/dvw_settle_cnt.sv
module dvw_settle_cnt #(
    parameter int SETTLE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

    logic [CW-1:0] cnt_q;

    // counter restarts whenever the settle phase is not active
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run)
            cnt_q <= '0;
        else if (cnt_q != LAST)
            cnt_q <= cnt_q + 1'b1;
    end

    assign expired = run && (cnt_q == LAST);
endmodule

// File: rtl/dvw_run_track.sv
module dvw_run_track #(
    parameter int TAP_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             rec,
    input  logic             pass,
    input  logic [TAP_W-1:0] tap,
    output logic [TAP_W-1:0] best_start,
    output logic [TAP_W:0]   best_len
);
    localparam logic [TAP_W:0] LEN_ONE = {{TAP_W{1'b0}}, 1'b1};

    logic             in_run_q;
    logic [TAP_W-1:0] cur_start_q;
    logic [TAP_W:0]   cur_len_q;
    logic [TAP_W-1:0] n_start;
    logic [TAP_W:0]   n_len;

    always_comb begin
        n_start = in_run_q ? cur_start_q : tap;
        n_len   = in_run_q ? cur_len_q + LEN_ONE : LEN_ONE;
    end

    // streaming longest-run search: no pass map is stored
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_run_q    <= 1'b0;
            cur_start_q <= '0;
            cur_len_q   <= '0;
            best_start  <= '0;
            best_len    <= '0;
        end else if (clr) begin
            in_run_q    <= 1'b0;
            cur_start_q <= '0;
            cur_len_q   <= '0;
            best_start  <= '0;
            best_len    <= '0;
        end else if (rec) begin
            if (pass) begin
                in_run_q    <= 1'b1;
                cur_start_q <= n_start;
                cur_len_q   <= n_len;
                if (n_len > best_len) begin
                    best_start <= n_start;
                    best_len   <= n_len;
                end
            end else begin
                in_run_q  <= 1'b0;
                cur_len_q <= '0;
            end
        end
    end
endmodule

// File: rtl/dvw_ofs_calc.sv
module dvw_ofs_calc #(
    parameter int TAP_W = 7
) (
    input  logic [TAP_W-1:0] best_start,
    input  logic [TAP_W:0]   best_len,
    input  logic [TAP_W-1:0] qc,
    output logic             found,
    output logic [TAP_W-1:0] w_start,
    output logic [TAP_W-1:0] w_end,
    output logic [TAP_W-1:0] mag,
    output logic             dir
);
    localparam logic [TAP_W-1:0] T_ONE = {{(TAP_W-1){1'b0}}, 1'b1};

    logic [TAP_W-1:0] span;
    logic [TAP_W-1:0] centre;

    always_comb begin
        found   = (best_len != '0);
        w_start = found ? best_start : '0;
        w_end   = found ? best_start + best_len[TAP_W-1:0] - T_ONE : '0;
        span    = w_end - w_start;
        centre  = w_start + (span >> 1);
        dir     = found && (centre < qc);
        if (!found)
            mag = '0;
        else if (dir)
            mag = qc - centre;
        else
            mag = centre - qc;
    end
endmodule

// File: rtl/dvw_scan_seq.sv
module dvw_scan_seq
    import dvw_scan_pkg::*;
#(
    parameter int TAP_W      = 7,
    parameter int SETTLE_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [TAP_W-1:0] qc_i,
    input  logic             test_done_i,
    input  logic             test_pass_i,
    output logic             ovr_en_o,
    output logic [TAP_W-1:0] ovr_tap_o,
    output logic             test_req_o,
    output logic [TAP_W-1:0] ofs_o,
    output logic             ofs_dir_o,
    output logic [TAP_W-1:0] win_start_o,
    output logic [TAP_W-1:0] win_end_o,
    output logic             done_o,
    output logic             err_o
);
    localparam logic [TAP_W-1:0] TAP_LAST = '1;

    dvw_state_e       state_q, state_d;
    logic [TAP_W-1:0] tap_q;
    logic [TAP_W-1:0] qc_q;
    logic             settle_done;
    logic             launch;
    logic             record;
    logic [TAP_W-1:0] best_start;
    logic [TAP_W:0]   best_len;
    logic             found;
    logic [TAP_W-1:0] c_start, c_end, c_mag;
    logic             c_dir;

    assign launch = start_i && ((state_q == ST_IDLE) || (state_q == ST_DONE));
    assign record = (state_q == ST_TEST) && test_done_i;

    dvw_settle_cnt #(.SETTLE_CYC(SETTLE_CYC)) settle_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q == ST_SETTLE),
        .expired (settle_done)
    );

    dvw_run_track #(.TAP_W(TAP_W)) track_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (launch),
        .rec        (record),
        .pass       (test_pass_i),
        .tap        (tap_q),
        .best_start (best_start),
        .best_len   (best_len)
    );

    dvw_ofs_calc #(.TAP_W(TAP_W)) calc_i (
        .best_start (best_start),
        .best_len   (best_len),
        .qc         (qc_q),
        .found      (found),
        .w_start    (c_start),
        .w_end      (c_end),
        .mag        (c_mag),
        .dir        (c_dir)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_SETTLE;
            ST_SETTLE: if (settle_done) state_d = ST_TEST;
            ST_TEST:   if (test_done_i)
                           state_d = (tap_q == TAP_LAST) ? ST_CALC : ST_SETTLE;
            ST_CALC:   state_d = ST_DONE;
            ST_DONE:   if (start_i) state_d = ST_SETTLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state-decoded outputs
    always_comb begin
        ovr_en_o   = 1'b0;
        test_req_o = 1'b0;
        done_o     = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_SETTLE: ovr_en_o = 1'b1;
            ST_TEST:   begin ovr_en_o = 1'b1; test_req_o = 1'b1; end
            ST_CALC:   ;
            ST_DONE:   done_o = 1'b1;
            default:   ;
        endcase
    end

    assign ovr_tap_o = tap_q;

    // scan position, captured quarter-cycle and latched result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tap_q       <= '0;
            qc_q        <= '0;
            ofs_o       <= '0;
            ofs_dir_o   <= 1'b0;
            win_start_o <= '0;
            win_end_o   <= '0;
            err_o       <= 1'b0;
        end else if (launch) begin
            tap_q       <= '0;
            qc_q        <= qc_i;
            ofs_o       <= '0;
            ofs_dir_o   <= 1'b0;
            win_start_o <= '0;
            win_end_o   <= '0;
            err_o       <= 1'b0;
        end else if (record && (tap_q != TAP_LAST)) begin
            tap_q <= tap_q + 1'b1;
        end else if (state_q == ST_CALC) begin
            ofs_o       <= c_mag;
            ofs_dir_o   <= c_dir;
            win_start_o <= c_start;
            win_end_o   <= c_end;
            err_o       <= !found;
        end
    end
endmodule

// File: rtl/dvw_scan_seq_chk.sv
module dvw_scan_seq_chk #(
    parameter int TAP_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             test_done_i,
    input logic             ovr_en_o,
    input logic [TAP_W-1:0] ovr_tap_o,
    input logic             test_req_o,
    input logic [TAP_W-1:0] ofs_o,
    input logic             ofs_dir_o,
    input logic [TAP_W-1:0] win_start_o,
    input logic [TAP_W-1:0] win_end_o,
    input logic             done_o,
    input logic             err_o
);
    // R3
    tap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (test_req_o && $past(test_req_o)) |-> $stable(ovr_tap_o));

    // R2
    req_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        test_req_o |-> ovr_en_o);

    // R4
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (test_req_o && test_done_i) |=> !test_req_o);

    // R8
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!ovr_en_o && !test_req_o));

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(ofs_o) && $stable(ofs_dir_o)));

    // R9
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (done_o && ofs_o == '0 && !ofs_dir_o && win_end_o == '0));

    // R5
    win_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> (win_start_o <= win_end_o));
endmodule

bind dvw_scan_seq dvw_scan_seq_chk #(.TAP_W(TAP_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .test_done_i (test_done_i),
    .ovr_en_o    (ovr_en_o),
    .ovr_tap_o   (ovr_tap_o),
    .test_req_o  (test_req_o),
    .ofs_o       (ofs_o),
    .ofs_dir_o   (ofs_dir_o),
    .win_start_o (win_start_o),
    .win_end_o   (win_end_o),
    .done_o      (done_o),
    .err_o       (err_o)
);

// File: tb/dvw_scan_seq_tb.sv
module dvw_scan_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TAP_W      = 7;
    localparam int SETTLE     = 4;
    localparam int NTAP       = 1 << TAP_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [TAP_W-1:0] qc_i = '0;
    logic test_done_i = 1'b0;
    logic test_pass_i = 1'b0;
    logic ovr_en_o, test_req_o, ofs_dir_o, done_o, err_o;
    logic [TAP_W-1:0] ovr_tap_o, ofs_o, win_start_o, win_end_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // programmed pass windows and checker latency
    int lo1, hi1, lo2, hi2, lat;
    // monitor state
    int exp_tap, n_tests, mon_err, hs_err, scnt;
    bit prev_req, pend, drv_done;
    int lcnt;
    logic [TAP_W-1:0] held_tap;

    always #(CLK_PERIOD/2) clk = ~clk;

    dvw_scan_seq #(.TAP_W(TAP_W), .SETTLE_CYC(SETTLE)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .qc_i(qc_i),
        .test_done_i(test_done_i), .test_pass_i(test_pass_i),
        .ovr_en_o(ovr_en_o), .ovr_tap_o(ovr_tap_o), .test_req_o(test_req_o),
        .ofs_o(ofs_o), .ofs_dir_o(ofs_dir_o), .win_start_o(win_start_o),
        .win_end_o(win_end_o), .done_o(done_o), .err_o(err_o)
    );

    function automatic bit tap_ok(int t);
        return (t >= lo1 && t <= hi1) || (t >= lo2 && t <= hi2);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // read checker model and per-tap monitor, both away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (ovr_en_o && !test_req_o) scnt++;
            if (test_req_o && !prev_req) begin
                if (scnt != SETTLE) mon_err++;
                if (int'(ovr_tap_o) != exp_tap) mon_err++;
                held_tap = ovr_tap_o;
                exp_tap++;
                n_tests++;
                scnt = 0;
            end
            if (test_req_o && prev_req && ovr_tap_o != held_tap) mon_err++;
            prev_req = test_req_o;

            if (drv_done) begin
                drv_done = 1'b0;
                if (test_req_o) hs_err++;
            end else if (test_req_o) begin
                if (!pend) begin pend = 1'b1; lcnt = lat; end
                if (lcnt == 0) begin
                    drv_done = 1'b1;
                    pend = 1'b0;
                    test_pass_i = tap_ok(int'(ovr_tap_o));
                end else lcnt--;
            end else if (pend) hs_err++;
            test_done_i = drv_done;
            if (!drv_done) test_pass_i = 1'b0;
        end
    end

    task automatic run_scan(string name, int q, int a1, int b1, int a2, int b2,
                            int l, bit poke);
        int bs, bl, cs, cl, es, ee, ctr, emag, edir;
        bit found;
        lo1 = a1; hi1 = b1; lo2 = a2; hi2 = b2; lat = l;
        exp_tap = 0; n_tests = 0; mon_err = 0; hs_err = 0; scnt = 0;
        // expected window from the requirements
        bs = 0; bl = 0; cs = 0; cl = 0;
        for (int t = 0; t < NTAP; t++) begin
            if (tap_ok(t)) begin
                if (cl == 0) cs = t;
                cl++;
                if (cl > bl) begin bl = cl; bs = cs; end
            end else cl = 0;
        end
        found = (bl > 0);
        es = found ? bs : 0;
        ee = found ? bs + bl - 1 : 0;
        ctr = (es + ee) / 2;
        edir = (found && ctr < q) ? 1 : 0;
        emag = !found ? 0 : (edir ? q - ctr : ctr - q);

        @(negedge clk);
        qc_i = TAP_W'(q);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        qc_i = TAP_W'(q ^ 7'h55); // later changes must not matter (R6)
        chk(!done_o && !err_o && ovr_en_o, "R10", {name, " restart clears done"},
            {done_o, err_o, ovr_en_o}, 1);
        if (poke) begin
            repeat (200) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (!done_o) @(negedge clk);
        chk(n_tests == NTAP && mon_err == 0, "R2", {name, " tap sequence"}, n_tests + mon_err, NTAP);
        chk(mon_err == 0, "R3", {name, " settle and hold"}, mon_err, 0);
        chk(hs_err == 0, "R4", {name, " handshake"}, hs_err, 0);
        chk(int'(win_start_o) == es, "R5", {name, " window start"}, win_start_o, es);
        chk(int'(win_end_o) == ee, "R5", {name, " window end"}, win_end_o, ee);
        chk(int'(ofs_o) == emag, "R6", {name, " offset"}, ofs_o, emag);
        chk(int'(ofs_dir_o) == edir, "R7", {name, " direction"}, ofs_dir_o, edir);
        chk(!ovr_en_o && !test_req_o, "R8", {name, " override released"}, ovr_en_o, 0);
        chk(int'(err_o) == (found ? 0 : 1), "R9", {name, " error flag"}, err_o, found ? 0 : 1);
        repeat (5) @(negedge clk);
        chk(done_o && int'(ofs_o) == emag, "R8", {name, " result held"}, ofs_o, emag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!ovr_en_o && !test_req_o && !done_o && !err_o && ofs_o == 0 && !ofs_dir_o,
            "R1", "in reset", {ovr_en_o, test_req_o, done_o, err_o}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(!ovr_en_o && !test_req_o && !done_o && !err_o, "R1", "idle after reset",
            {ovr_en_o, test_req_o, done_o, err_o}, 0);

        run_scan("interior",  50, 40, 70, 200, 0,   2, 1'b1);
        run_scan("below_qc",  60, 10, 20, 200, 0,   0, 1'b0);
        run_scan("tie",       30,  5, 14,  90, 99,  1, 1'b0);
        run_scan("top_edge",  20,  5,  9, 100, 127, 3, 1'b0);
        run_scan("none",      40, 200, 0, 200, 0,   1, 1'b0);
        run_scan("all",       63,  0, 127, 200, 0,  0, 1'b0);
        run_scan("tap0_only", 127, 0,  0, 200, 0,   2, 1'b0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule